// File: doc/BRIEF.md
# Data-move bus cycle sequencer

This block turns one decoded register/memory move into the ordered list of bus micro-cycles that the move performs. A decoder hands it the source addressing mode and register, the destination addressing mode and register, and the operand size, using a one-cycle start pulse. The sequencer then offers the cycle kinds one at a time to a bus model over a valid/ready handshake: program-word fetch, word read, high-half read of a long, word write, high-half write of a long, and internal idle. After the last cycle is accepted it raises a one-cycle done pulse.

The order depends on the mode pair and the size. Long operands become a high-half cycle followed by a word cycle. Pre-decrement and the indexed modes put an idle cycle first. Extension words of the source, such as displacements, absolute addresses and immediates, appear as extra fetch cycles. Every move finishes with one fetch cycle.

Alongside the bus cycles, the block emits register-update strobes for post-increment and pre-decrement, each with the register number and the step amount. It does not move data, compute flags or form addresses. Mode pairs it cannot sequence produce an error pulse and no bus cycles.

Top module: `move_cycle_seq`

## Requirements
- R1: Encoding. Size 0 is byte, 1 is word, 2 is long, and 3 is reserved. A mode field of 0..6 selects data register, address register, indirect, post-increment, pre-decrement, 16-bit displacement or indexed. Mode 7 uses the register field: 0 is absolute short, 1 is absolute long, 2 is PC displacement, 3 is PC indexed, 4 is immediate. Cycle kinds are 0 fetch, 1 read, 2 read-high, 3 write, 4 write-high and 5 idle. A move between registers (mode 0 or 1 on both sides) emits exactly one fetch.
- R2: A source of indirect or post-increment mode emits a read (read-high then read for long) followed by the final fetch. An absolute-short source adds one leading fetch. An absolute-long source adds two, so for long the order is fetch, fetch, read-high, read, fetch.
- R3: A pre-decrement source emits idle, then the read cycles, then the final fetch.
- R4: Displacement sources (modes 5 and 7/2) emit fetch, read cycles, fetch. Indexed sources (modes 6 and 7/3) emit one idle cycle in front of that.
- R5: An immediate source emits one fetch for byte or word and two for long, then the destination cycles. Into a register this gives two or three fetches.
- R6: An indirect or post-increment destination inserts a write (write-high then write for long) after the source cycles and before the final fetch.
- R7: After reset the block is idle with no cycle offered and no pulse. The first cycle is offered one clock after start. The offered kind stays stable while ready is low, and the next kind follows only after an accepted cycle.
- R8: Done is high for exactly one clock, the clock after the last cycle is accepted. No cycle is offered while done is high, and the block is idle the clock after.
- R9: The update step is 1, 2 or 4 for byte, word or long. A pre-decrement source strobes the source register, with the decrement flag, in the first offered cycle. Post-increment sources and destinations strobe with done.
- R10: A byte access through register 7 steps by 2.
- R11: A reserved size, a reserved mode-7 code, a destination other than the modes 0 to 3, or a byte move using an address register raises err for one clock, one clock after start. No cycle is offered and no done is given.
- R12: A start while the block is busy is ignored. The running sequence is unchanged and no error results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| size_i | input | 2 | Operand size code |
| src_mode_i | input | 3 | Source mode field |
| src_reg_i | input | REG_W | Source register field |
| dst_mode_i | input | 3 | Destination mode field |
| dst_reg_i | input | REG_W | Destination register field |
| busy_o | output | 1 | Sequence in progress |
| cyc_valid_o | output | 1 | A cycle kind is offered |
| cyc_kind_o | output | 3 | Offered cycle kind |
| cyc_ready_i | input | 1 | Bus model accepts the offered cycle |
| done_o | output | 1 | One-clock completion pulse |
| err_o | output | 1 | One-clock pulse for an unsupported request |
| src_adj_o | output | 1 | Source register update strobe |
| src_adj_dec_o | output | 1 | Source update is a decrement |
| src_adj_reg_o | output | REG_W | Source register to update |
| src_adj_step_o | output | 3 | Source update amount |
| dst_adj_o | output | 1 | Destination register update strobe |
| dst_adj_reg_o | output | REG_W | Destination register to update |
| dst_adj_step_o | output | 3 | Destination update amount |

## Verification
Each result has a fixed time after its stimulus. The err pulse, the first offered cycle and the pre-decrement strobe come one clock after start. Each later kind appears in the clock after the previous one is accepted. Done and the post-increment strobes come one clock after the final acceptance, and idle comes one clock after done. The bench drives and samples on the falling edge. It decides ready before it reads the offered kind, so it knows exactly which edge accepts a cycle, and it checks done, the strobes and idle at the falling edges that follow. The sweep covers every source mode and register, every destination mode, and all four sizes, with ready stalled in a pseudo-random pattern.

// File: rtl/move_cycle_seq_pkg.sv
package move_cycle_seq_pkg;

   localparam int KIND_W = 3;
   localparam int STEP_W = 3;

   typedef enum logic [KIND_W-1:0] {
      CK_FETCH   = 3'd0,
      CK_READ    = 3'd1,
      CK_READ_HI = 3'd2,
      CK_WRITE   = 3'd3,
      CK_WRITE_HI= 3'd4,
      CK_IDLE    = 3'd5
   } cyc_kind_e;

   typedef enum logic [3:0] {
      AK_DATA, AK_ADDR, AK_IND, AK_POST, AK_PRE, AK_DISP, AK_INDEX,
      AK_ABS_W, AK_ABS_L, AK_PC_DISP, AK_PC_INDEX, AK_IMM, AK_BAD
   } am_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_RSVD = 2'd3
   } size_e;

   typedef enum logic [1:0] {
      ST_IDLE, ST_RUN, ST_DONE
   } issue_st_e;

endpackage

// File: rtl/move_cycle_seq_class.sv
module move_cycle_seq_class
   import move_cycle_seq_pkg::*;
#(
   parameter int REG_W         = 3,
   parameter int SP_INDEX      = 7,
   parameter bit SP_WORD_ALIGN = 1'b1
)(
   input  logic [2:0]        mode_i,
   input  logic [REG_W-1:0]  reg_i,
   input  size_e             size_i,
   output am_e               am_o,
   output logic [STEP_W-1:0] step_o
);
   localparam int SUB_W = 3;

   logic             hi_clear;
   logic [SUB_W-1:0] sub;
   logic             byte_widen;

   assign sub = reg_i[SUB_W-1:0];

   // Upper register bits must be clear for the mode-7 sub-codes
   generate
      if (REG_W > SUB_W) begin : g_wide
         assign hi_clear = (reg_i[REG_W-1:SUB_W] == '0);
      end else begin : g_narrow
         assign hi_clear = 1'b1;
      end
   endgenerate

   // Byte steps through the stack register stay even when enabled
   generate
      if (SP_WORD_ALIGN) begin : g_sp_align
         assign byte_widen = (reg_i == REG_W'(SP_INDEX));
      end else begin : g_no_align
         assign byte_widen = 1'b0;
      end
   endgenerate

   always_comb begin
      case (mode_i)
         3'd0: am_o = AK_DATA;
         3'd1: am_o = AK_ADDR;
         3'd2: am_o = AK_IND;
         3'd3: am_o = AK_POST;
         3'd4: am_o = AK_PRE;
         3'd5: am_o = AK_DISP;
         3'd6: am_o = AK_INDEX;
         default: begin
            if (!hi_clear) begin
               am_o = AK_BAD;
            end else begin
               case (sub)
                  3'd0:    am_o = AK_ABS_W;
                  3'd1:    am_o = AK_ABS_L;
                  3'd2:    am_o = AK_PC_DISP;
                  3'd3:    am_o = AK_PC_INDEX;
                  3'd4:    am_o = AK_IMM;
                  default: am_o = AK_BAD;
               endcase
            end
         end
      endcase
   end

   always_comb begin
      case (size_i)
         SZ_BYTE: step_o = byte_widen ? STEP_W'(2) : STEP_W'(1);
         SZ_WORD: step_o = STEP_W'(2);
         SZ_LONG: step_o = STEP_W'(4);
         default: step_o = '0;
      endcase
   end

endmodule

// File: rtl/move_cycle_seq_plan.sv
module move_cycle_seq_plan
   import move_cycle_seq_pkg::*;
#(
   parameter  int MAX_STEPS = 8,
   localparam int IDX_W     = $clog2(MAX_STEPS),
   localparam int CNT_W     = $clog2(MAX_STEPS + 1)
)(
   input  am_e                              src_am_i,
   input  am_e                              dst_am_i,
   input  size_e                            size_i,
   output logic [MAX_STEPS-1:0][KIND_W-1:0] steps_o,
   output logic [CNT_W-1:0]                 len_o,
   output logic                             bad_o
);
   logic             is_long;
   logic             lead_idle;
   logic             src_mem;
   logic             ext_one;
   logic             ext_two;
   logic             dst_mem;
   logic             dst_ok;
   logic [CNT_W-1:0] n;

   always_comb begin
      is_long   = (size_i == SZ_LONG);
      lead_idle = src_am_i inside {AK_PRE, AK_INDEX, AK_PC_INDEX};
      src_mem   = src_am_i inside {AK_IND, AK_POST, AK_PRE, AK_DISP, AK_INDEX,
                                   AK_ABS_W, AK_ABS_L, AK_PC_DISP, AK_PC_INDEX};
      ext_one   = src_am_i inside {AK_DISP, AK_INDEX, AK_ABS_W, AK_ABS_L,
                                   AK_PC_DISP, AK_PC_INDEX, AK_IMM};
      ext_two   = (src_am_i == AK_ABS_L) || ((src_am_i == AK_IMM) && is_long);
      dst_mem   = dst_am_i inside {AK_IND, AK_POST};
      dst_ok    = dst_am_i inside {AK_DATA, AK_ADDR, AK_IND, AK_POST};
      bad_o     = (size_i == SZ_RSVD) || (src_am_i == AK_BAD) || !dst_ok ||
                  ((size_i == SZ_BYTE) && ((src_am_i == AK_ADDR) || (dst_am_i == AK_ADDR)));
   end

   // Append cycles in bus order: lead idle, extension fetches, reads, writes, final fetch
   always_comb begin
      n = '0;
      for (int i = 0; i < MAX_STEPS; i++) begin
         steps_o[i] = CK_FETCH;
      end
      if (lead_idle) begin
         steps_o[n[IDX_W-1:0]] = CK_IDLE;
         n = n + CNT_W'(1);
      end
      if (ext_one) begin
         steps_o[n[IDX_W-1:0]] = CK_FETCH;
         n = n + CNT_W'(1);
      end
      if (ext_two) begin
         steps_o[n[IDX_W-1:0]] = CK_FETCH;
         n = n + CNT_W'(1);
      end
      if (src_mem) begin
         if (is_long) begin
            steps_o[n[IDX_W-1:0]] = CK_READ_HI;
            n = n + CNT_W'(1);
         end
         steps_o[n[IDX_W-1:0]] = CK_READ;
         n = n + CNT_W'(1);
      end
      if (dst_mem) begin
         if (is_long) begin
            steps_o[n[IDX_W-1:0]] = CK_WRITE_HI;
            n = n + CNT_W'(1);
         end
         steps_o[n[IDX_W-1:0]] = CK_WRITE;
         n = n + CNT_W'(1);
      end
      steps_o[n[IDX_W-1:0]] = CK_FETCH;
      n = n + CNT_W'(1);
      len_o = n;
   end

endmodule

// File: rtl/move_cycle_seq_issue.sv
module move_cycle_seq_issue
   import move_cycle_seq_pkg::*;
#(
   parameter  int MAX_STEPS = 8,
   localparam int CNT_W     = $clog2(MAX_STEPS + 1)
)(
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             load_i,
   input  logic [MAX_STEPS-1:0][KIND_W-1:0] steps_i,
   input  logic [CNT_W-1:0]                 len_i,
   input  logic                             ready_i,
   output logic                             valid_o,
   output logic [KIND_W-1:0]                kind_o,
   output logic                             first_o,
   output logic                             done_o,
   output logic                             busy_o
);
   issue_st_e        st_q;
   logic [CNT_W-1:0] left_q;
   logic             first_q;
   logic             accept;
   logic [KIND_W-1:0] slot_w [MAX_STEPS+1];

   assign accept = (st_q == ST_RUN) && ready_i;
   assign slot_w[MAX_STEPS] = CK_IDLE;

   // Shift queue: slot 0 is always the offered cycle
   generate
      for (genvar i = 0; i < MAX_STEPS; i++) begin : g_slot
         logic [KIND_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= CK_IDLE;
            end else if (load_i) begin
               q <= steps_i[i];
            end else if (accept) begin
               q <= slot_w[i+1];
            end
         end
         assign slot_w[i] = q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         left_q  <= '0;
         first_q <= 1'b0;
      end else begin
         first_q <= load_i;
         case (st_q)
            ST_IDLE: begin
               if (load_i) begin
                  st_q   <= ST_RUN;
                  left_q <= len_i;
               end
            end
            ST_RUN: begin
               if (ready_i) begin
                  left_q <= left_q - CNT_W'(1);
                  if (left_q == CNT_W'(1)) begin
                     st_q <= ST_DONE;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign valid_o = (st_q == ST_RUN);
   assign kind_o  = slot_w[0];
   assign first_o = first_q;
   assign done_o  = (st_q == ST_DONE);
   assign busy_o  = (st_q != ST_IDLE);

endmodule

// File: rtl/move_cycle_seq.sv
module move_cycle_seq
   import move_cycle_seq_pkg::*;
#(
   parameter int REG_W         = 3,
   parameter int MAX_STEPS     = 8,
   parameter int SP_INDEX      = 7,
   parameter bit SP_WORD_ALIGN = 1'b1
)(
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 start_i,
   input  logic [1:0]                           size_i,
   input  logic [2:0]                           src_mode_i,
   input  logic [REG_W-1:0]                     src_reg_i,
   input  logic [2:0]                           dst_mode_i,
   input  logic [REG_W-1:0]                     dst_reg_i,
   output logic                                 busy_o,
   output logic                                 cyc_valid_o,
   output logic [move_cycle_seq_pkg::KIND_W-1:0] cyc_kind_o,
   input  logic                                 cyc_ready_i,
   output logic                                 done_o,
   output logic                                 err_o,
   output logic                                 src_adj_o,
   output logic                                 src_adj_dec_o,
   output logic [REG_W-1:0]                     src_adj_reg_o,
   output logic [move_cycle_seq_pkg::STEP_W-1:0] src_adj_step_o,
   output logic                                 dst_adj_o,
   output logic [REG_W-1:0]                     dst_adj_reg_o,
   output logic [move_cycle_seq_pkg::STEP_W-1:0] dst_adj_step_o
);
   localparam int CNT_W     = $clog2(MAX_STEPS + 1);
   localparam int LONGEST   = 7;

   generate
      if (REG_W < 3) begin : g_chk_reg
         $error("move_cycle_seq: REG_W must be at least 3");
      end
      if (MAX_STEPS < LONGEST) begin : g_chk_depth
         $error("move_cycle_seq: MAX_STEPS too small for the longest sequence");
      end
      if (SP_INDEX >= (1 << REG_W)) begin : g_chk_sp
         $error("move_cycle_seq: SP_INDEX outside the register file");
      end
   endgenerate

   size_e                            size_w;
   am_e                              src_am;
   am_e                              dst_am;
   logic [STEP_W-1:0]                src_step;
   logic [STEP_W-1:0]                dst_step;
   logic [MAX_STEPS-1:0][KIND_W-1:0] plan_steps;
   logic [CNT_W-1:0]                 plan_len;
   logic                             plan_bad;
   logic                             take;
   logic                             load;
   logic                             first;
   logic                             err_q;
   logic                             src_pre_q;
   logic                             src_post_q;
   logic                             dst_post_q;
   logic [REG_W-1:0]                 src_reg_q;
   logic [REG_W-1:0]                 dst_reg_q;
   logic [STEP_W-1:0]                src_step_q;
   logic [STEP_W-1:0]                dst_step_q;

   assign size_w = size_e'(size_i);

   move_cycle_seq_class #(
      .REG_W(REG_W), .SP_INDEX(SP_INDEX), .SP_WORD_ALIGN(SP_WORD_ALIGN)
   ) u_src_class (
      .mode_i(src_mode_i), .reg_i(src_reg_i), .size_i(size_w),
      .am_o(src_am), .step_o(src_step)
   );

   move_cycle_seq_class #(
      .REG_W(REG_W), .SP_INDEX(SP_INDEX), .SP_WORD_ALIGN(SP_WORD_ALIGN)
   ) u_dst_class (
      .mode_i(dst_mode_i), .reg_i(dst_reg_i), .size_i(size_w),
      .am_o(dst_am), .step_o(dst_step)
   );

   move_cycle_seq_plan #(.MAX_STEPS(MAX_STEPS)) u_plan (
      .src_am_i(src_am), .dst_am_i(dst_am), .size_i(size_w),
      .steps_o(plan_steps), .len_o(plan_len), .bad_o(plan_bad)
   );

   assign take = start_i && !busy_o;
   assign load = take && !plan_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q      <= 1'b0;
         src_pre_q  <= 1'b0;
         src_post_q <= 1'b0;
         dst_post_q <= 1'b0;
         src_reg_q  <= '0;
         dst_reg_q  <= '0;
         src_step_q <= '0;
         dst_step_q <= '0;
      end else begin
         err_q <= take && plan_bad;
         if (load) begin
            src_pre_q  <= (src_am == AK_PRE);
            src_post_q <= (src_am == AK_POST);
            dst_post_q <= (dst_am == AK_POST);
            src_reg_q  <= src_reg_i;
            dst_reg_q  <= dst_reg_i;
            src_step_q <= src_step;
            dst_step_q <= dst_step;
         end
      end
   end

   move_cycle_seq_issue #(.MAX_STEPS(MAX_STEPS)) u_issue (
      .clk(clk), .rst_n(rst_n), .load_i(load), .steps_i(plan_steps),
      .len_i(plan_len), .ready_i(cyc_ready_i), .valid_o(cyc_valid_o),
      .kind_o(cyc_kind_o), .first_o(first), .done_o(done_o), .busy_o(busy_o)
   );

   assign err_o          = err_q;
   assign src_adj_o      = (first && src_pre_q) || (done_o && src_post_q);
   assign src_adj_dec_o  = first && src_pre_q;
   assign src_adj_reg_o  = src_reg_q;
   assign src_adj_step_o = src_step_q;
   assign dst_adj_o      = done_o && dst_post_q;
   assign dst_adj_reg_o  = dst_reg_q;
   assign dst_adj_step_o = dst_step_q;

endmodule

// File: rtl/move_cycle_seq_chk.sv
module move_cycle_seq_chk #(
   parameter int REG_W         = 3,
   parameter int SP_INDEX      = 7,
   parameter bit SP_WORD_ALIGN = 1'b1
)(
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             busy_o,
   input logic             cyc_valid_o,
   input logic [2:0]       cyc_kind_o,
   input logic             cyc_ready_i,
   input logic             done_o,
   input logic             err_o,
   input logic             src_adj_o,
   input logic             src_adj_dec_o,
   input logic [2:0]       src_adj_step_o,
   input logic             dst_adj_o,
   input logic [REG_W-1:0] dst_adj_reg_o,
   input logic [2:0]       dst_adj_step_o
);
   p_kind_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid_o && !cyc_ready_i |=> cyc_valid_o && $stable(cyc_kind_o));

   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !cyc_valid_o && !done_o);

   p_done_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(cyc_valid_o && cyc_ready_i) && !cyc_valid_o);

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && !busy_o);

   p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !cyc_valid_o && !done_o && !busy_o);

   p_err_from_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(start_i));

   p_busy_from_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   p_src_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      src_adj_o |-> $countones(src_adj_step_o) == 1);

   p_dst_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dst_adj_o |-> $countones(dst_adj_step_o) == 1 && done_o);

   p_predec_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      src_adj_dec_o |-> src_adj_o && cyc_valid_o);

   p_sp_even_r10: assert property (@(posedge clk) disable iff (!rst_n)
      SP_WORD_ALIGN && dst_adj_o && (dst_adj_reg_o == REG_W'(SP_INDEX)) |-> dst_adj_step_o != 3'd1);

endmodule

bind move_cycle_seq move_cycle_seq_chk #(
   .REG_W(REG_W), .SP_INDEX(SP_INDEX), .SP_WORD_ALIGN(SP_WORD_ALIGN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
   .cyc_valid_o(cyc_valid_o), .cyc_kind_o(cyc_kind_o), .cyc_ready_i(cyc_ready_i),
   .done_o(done_o), .err_o(err_o), .src_adj_o(src_adj_o),
   .src_adj_dec_o(src_adj_dec_o), .src_adj_step_o(src_adj_step_o),
   .dst_adj_o(dst_adj_o), .dst_adj_reg_o(dst_adj_reg_o),
   .dst_adj_step_o(dst_adj_step_o)
);

// File: tb/move_cycle_seq_bench.sv
`timescale 1ns/1ps
module move_cycle_seq_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [1:0] size_i = '0;
   logic [2:0] src_mode_i = '0, src_reg_i = '0, dst_mode_i = '0, dst_reg_i = '0;
   logic       cyc_ready_i = 1'b0;
   logic       busy_o, cyc_valid_o, done_o, err_o;
   logic [2:0] cyc_kind_o;
   logic       src_adj_o, src_adj_dec_o, dst_adj_o;
   logic [2:0] src_adj_reg_o, dst_adj_reg_o, src_adj_step_o, dst_adj_step_o;

   int checks = 0;
   int failures = 0;
   int exp_k[16];
   int exp_len;
   bit exp_bad;
   logic [7:0] lfsr = 8'hA5;

   always #2 clk = ~clk;

   move_cycle_seq u_move_cycle_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
      .src_mode_i(src_mode_i), .src_reg_i(src_reg_i),
      .dst_mode_i(dst_mode_i), .dst_reg_i(dst_reg_i),
      .busy_o(busy_o), .cyc_valid_o(cyc_valid_o), .cyc_kind_o(cyc_kind_o),
      .cyc_ready_i(cyc_ready_i), .done_o(done_o), .err_o(err_o),
      .src_adj_o(src_adj_o), .src_adj_dec_o(src_adj_dec_o),
      .src_adj_reg_o(src_adj_reg_o), .src_adj_step_o(src_adj_step_o),
      .dst_adj_o(dst_adj_o), .dst_adj_reg_o(dst_adj_reg_o),
      .dst_adj_step_o(dst_adj_step_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // 0 D,1 A,2 ind,3 post,4 pre,5 disp,6 idx,7 absW,8 absL,9 pcd,10 pcx,11 imm,12 bad
   function automatic int classify(input int m, input int r);
      if (m < 7) return m;
      if (r <= 4) return 7 + r;
      return 12;
   endfunction

   function automatic int step_of(input int sz, input int r);
      if (sz == 0) return (r == 7) ? 2 : 1;
      if (sz == 1) return 2;
      return 4;
   endfunction

   function automatic string tag_of(input int sc, input int dc);
      if (dc == 2 || dc == 3) return "R6";
      if (sc == 11) return "R5";
      if (sc == 5 || sc == 6 || sc == 9 || sc == 10) return "R4";
      if (sc == 4) return "R3";
      if (sc == 2 || sc == 3 || sc == 7 || sc == 8) return "R2";
      return "R1";
   endfunction

   task automatic push(input int k);
      exp_k[exp_len] = k;
      exp_len++;
   endtask

   task automatic expect_seq(input int sz, input int sc, input int dc);
      bit lng;
      int ext;
      lng = (sz == 2);
      exp_len = 0;
      exp_bad = (sz == 3) || (sc == 12) || (dc > 3) || (sz == 0 && (sc == 1 || dc == 1));
      if (sc == 4 || sc == 6 || sc == 10) push(5);
      ext = 0;
      if (sc == 5 || sc == 6 || sc == 7 || sc == 9 || sc == 10) ext = 1;
      if (sc == 8) ext = 2;
      if (sc == 11) ext = lng ? 2 : 1;
      for (int i = 0; i < ext; i++) push(0);
      if (sc >= 2 && sc <= 10) begin
         if (lng) push(2);
         push(1);
      end
      if (dc == 2 || dc == 3) begin
         if (lng) push(4);
         push(3);
      end
      push(0);
   endtask

   task automatic run_one(input int sz, input int sm, input int sr, input int dm,
                          input int dr, input bit poke);
      int sc, dc, acc, guard, got[16], prev_kind;
      bit prev_stall;
      string t;
      sc = classify(sm, sr);
      dc = classify(dm, dr);
      expect_seq(sz, sc, dc);
      t = tag_of(sc, dc);
      @(negedge clk);
      start_i = 1'b1; size_i = 2'(sz);
      src_mode_i = 3'(sm); src_reg_i = 3'(sr); dst_mode_i = 3'(dm); dst_reg_i = 3'(dr);
      @(negedge clk);
      start_i = 1'b0;
      if (exp_bad) begin
         check(err_o == 1'b1, "R11 err pulse", int'(err_o), 1);
         check(!cyc_valid_o && !busy_o, "R11 no cycle", int'(cyc_valid_o), 0);
         @(negedge clk);
         check(!err_o && !done_o && !cyc_valid_o, "R11 err single", int'(err_o), 0);
         return;
      end
      check(!err_o, "R11 no err on legal", int'(err_o), 0);
      check(src_adj_o == (sc == 4), "R9 predec strobe", int'(src_adj_o), int'(sc == 4));
      if (sc == 4) begin
         check(src_adj_dec_o && src_adj_reg_o == 3'(sr), "R9 predec reg", int'(src_adj_reg_o), sr);
         check(int'(src_adj_step_o) == step_of(sz, sr), (sz == 0 && sr == 7) ? "R10 predec step" : "R9 predec step",
               int'(src_adj_step_o), step_of(sz, sr));
      end
      acc = 0; guard = 0; prev_stall = 1'b0; prev_kind = 0;
      while (acc < exp_len && guard < 64) begin
         if (guard > 0) @(negedge clk);
         if (poke && guard == 1) begin
            start_i = 1'b1; size_i = 2'd3; src_mode_i = '0; dst_mode_i = '0;
         end else begin
            start_i = 1'b0;
         end
         if (poke) check(!err_o, "R12 no err while busy", int'(err_o), 0);
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         cyc_ready_i = lfsr[0] | lfsr[1];
         if (!cyc_valid_o || done_o) begin
            check(1'b0, "R7 valid held until accepted", int'(cyc_valid_o), 1);
         end else begin
            if (prev_stall && int'(cyc_kind_o) != prev_kind)
               check(1'b0, "R7 kind stable while stalled", int'(cyc_kind_o), prev_kind);
            prev_stall = !cyc_ready_i;
            prev_kind = int'(cyc_kind_o);
            if (cyc_ready_i) begin
               got[acc] = int'(cyc_kind_o);
               acc++;
            end
         end
         guard++;
      end
      start_i = 1'b0;
      for (int i = 0; i < exp_len; i++) check(got[i] == exp_k[i], t, got[i], exp_k[i]);
      @(negedge clk);
      cyc_ready_i = 1'b0;
      check(done_o == 1'b1, "R8 done after last accept", int'(done_o), 1);
      check(!cyc_valid_o, "R8 no cycle with done", int'(cyc_valid_o), 0);
      check(src_adj_o == (sc == 3), "R9 src postinc strobe", int'(src_adj_o), int'(sc == 3));
      check(dst_adj_o == (dc == 3), "R9 dst postinc strobe", int'(dst_adj_o), int'(dc == 3));
      if (sc == 3)
         check(int'(src_adj_step_o) == step_of(sz, sr) && !src_adj_dec_o && src_adj_reg_o == 3'(sr),
               (sz == 0 && sr == 7) ? "R10 src step" : "R9 src step", int'(src_adj_step_o), step_of(sz, sr));
      if (dc == 3)
         check(int'(dst_adj_step_o) == step_of(sz, dr) && dst_adj_reg_o == 3'(dr),
               (sz == 0 && dr == 7) ? "R10 dst step" : "R9 dst step", int'(dst_adj_step_o), step_of(sz, dr));
      @(negedge clk);
      check(!done_o && !busy_o, "R8 idle after done", int'(busy_o), 0);
      if (poke) check(!err_o && !cyc_valid_o, "R12 busy start ignored", int'(cyc_valid_o), 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !cyc_valid_o && !done_o && !err_o, "R7 reset idle", int'(busy_o), 0);
      check(!src_adj_o && !dst_adj_o, "R7 reset strobes", int'(src_adj_o), 0);
      // directed: absolute long source, long, into post-increment, with a start while busy
      run_one(2, 7, 1, 3, 2, 1'b1);
      // directed: register to register
      run_one(1, 0, 3, 0, 4, 1'b0);
      for (int sz = 0; sz < 4; sz++)
         for (int sm = 0; sm < 8; sm++)
            for (int sr = 0; sr < 8; sr++)
               for (int dm = 0; dm < 8; dm++)
                  for (int dr = 0; dr < 8; dr++)
                     if (dm == 7 || dr == 3 || dr == 7) run_one(sz, sm, sr, dm, dr, 1'b0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule